// File: doc/BRIEF.md
# L1 Cache Parity Guard with Error Injection

This block stores the contents of a small two-sided level-one cache array (an instruction side and a data side). It keeps one even-parity bit for each stored byte and checks those bits on every read. Software can arm a fault-injection mode on either side. While that mode is armed, the block writes every parity bit it generates inverted. A later read of the affected bytes then raises a parity error, and the recovery software can be tested on real hardware paths.

Each side has a control register with a check-enable bit and an inject bit. The inject bit is accepted only in a write that also sets check-enable. A whole line is written by a line fill, which targets either side. The data side also takes single-byte stores and two whole-line operations: zero-line and allocate. Both whole-line operations write zeros. A read returns the line and a parity-error flag one cycle after the request. The flag is raised only when the side's check-enable bit is set.

Top module: `l1_parity_guard`

## Requirements
- R1: After reset both control readbacks are 2'b00 ({inject, check}) and `rd_perr` is 0.
- R2: A control write stores check = `cfg_wdata[0]` and inject = `cfg_wdata[1] & cfg_wdata[0]`. A write of 2'b10 leaves inject cleared, and a write with bit 0 clear also clears a set inject bit. `cfg_sel` is 0 for the instruction side and 1 for the data side.
- R3: A read issued with `rd_en` in cycle N returns the whole stored line on `rd_data` after the clock edge that ends cycle N, and `rd_perr` is valid in that same cycle. Byte b of a line occupies bits [8b+7:8b].
- R4: While the instruction-side inject bit is set, an instruction line fill stores every parity bit inverted, so a checked read of that line flags an error.
- R5: While the data-side inject bit is set, a data line fill stores every parity bit inverted, so a checked read of that line flags an error.
- R6: A data-side store with `st_kind` 0 writes `st_data` into byte `st_byte`. Kind 1 (zero-line) and kind 2 (allocate) write zeros to the whole line. Kind 3 writes nothing. While data-side inject is set, the parity of every byte written by kinds 0 to 2 is inverted.
- R7: `rd_perr` is raised only if the read side's check-enable bit was 1 when the read was requested. A corrupted line read with checking off gives no error.
- R8: A fill made while injection is off stores correct parity, so a rewritten line reads back clean.
- R9: When a store and a fill reach the same data line in one cycle, the store's bytes take the store data and the other bytes take the fill data. A read of that line in the same cycle returns the contents held before the write.
- R10: The injection state of one side does not affect fills made on the other side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | 1 | Control register select: 0 instruction, 1 data |
| cfg_wdata | input | 2 | Write value {inject, check} |
| icfg | output | 2 | Instruction-side control readback {inject, check} |
| dcfg | output | 2 | Data-side control readback {inject, check} |
| fill_en | input | 1 | Line fill strobe |
| fill_side | input | 1 | Fill target side: 0 instruction, 1 data |
| fill_line | input | AW | Fill line index |
| fill_data | input | LINE_BYTES*8 | Fill line contents |
| st_en | input | 1 | Data-side store strobe |
| st_kind | input | 2 | Store kind: 0 byte, 1 zero-line, 2 allocate, 3 none |
| st_line | input | AW | Store line index |
| st_byte | input | BW | Byte offset for a byte store |
| st_data | input | 8 | Byte store data |
| rd_en | input | 1 | Read request |
| rd_side | input | 1 | Read side: 0 instruction, 1 data |
| rd_line | input | AW | Read line index |
| rd_data | output | LINE_BYTES*8 | Line returned by the last read |
| rd_perr | output | 1 | Parity error on the last read |

## Verification
The bench makes two functions meet in one cycle. A line fill, a byte store and a read all address the same data line on a single clock edge. The read must return the line as it stood before that edge. A following read must show the store's byte on top of the fill's other bytes with clean parity. Separate scenarios also change a control register and then read lines written under the previous setting. These scenarios show that the check decision follows the register state at read time, and that the corruption stays with the line until the line is rewritten.

// File: rtl/l1pg_pkg.sv
package l1pg_pkg;
  localparam logic SIDE_INSTR = 1'b0;
  localparam logic SIDE_DATA  = 1'b1;

  typedef enum logic [1:0] {
    STK_BYTE  = 2'd0,
    STK_ZERO  = 2'd1,
    STK_ALLOC = 2'd2,
    STK_NONE  = 2'd3
  } st_kind_e;

  typedef struct packed {
    logic inject;
    logic check;
  } side_ctl_t;
endpackage

// File: rtl/l1pg_ctrl.sv
module l1pg_ctrl
  import l1pg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_we,
  input  logic      cfg_sel,
  input  logic [1:0] cfg_wdata,
  output side_ctl_t ictl,
  output side_ctl_t dctl
);
  side_ctl_t ictl_q, ictl_d, dctl_q, dctl_d, wr_val;

  always_comb begin
    wr_val.check  = cfg_wdata[0];
    wr_val.inject = cfg_wdata[1] & cfg_wdata[0];
    ictl_d = ictl_q;
    dctl_d = dctl_q;
    if (cfg_we && cfg_sel == SIDE_INSTR) ictl_d = wr_val;
    if (cfg_we && cfg_sel == SIDE_DATA)  dctl_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ictl_q <= '0;
      dctl_q <= '0;
    end else begin
      ictl_q <= ictl_d;
      dctl_q <= dctl_d;
    end
  end

  assign ictl = ictl_q;
  assign dctl = dctl_q;

  assert_inject_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_wdata[0]) |=> !($past(cfg_sel) ? dctl_q.inject : ictl_q.inject));

  assert_inject_needs_check_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ictl_q.inject |-> ictl_q.check) and (dctl_q.inject |-> dctl_q.check));
endmodule

// File: rtl/l1pg_lpar.sv
module l1pg_lpar #(
  parameter int LB = 4
) (
  input  logic [LB*8-1:0] data,
  input  logic            flip,
  output logic [LB-1:0]   par
);
  for (genvar b = 0; b < LB; b++) begin : g_byte
    assign par[b] = (^data[b*8 +: 8]) ^ flip;
  end
endmodule

// File: rtl/l1pg_bank.sv
module l1pg_bank #(
  parameter int LINES = 8,
  parameter int LB    = 4,
  localparam int AW   = $clog2(LINES),
  localparam int LW   = LB * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_en,
  input  logic [AW-1:0] fill_line,
  input  logic [LW-1:0] fill_data,
  input  logic          fill_flip,
  input  logic [LB-1:0] st_be,
  input  logic [AW-1:0] st_line,
  input  logic [LW-1:0] st_data,
  input  logic          st_flip,
  input  logic [AW-1:0] rd_line,
  output logic [LW-1:0] rd_data,
  output logic [LB-1:0] rd_bad
);
  logic [LW-1:0] data_mem [LINES];
  logic [LB-1:0] par_mem  [LINES];
  logic [LB-1:0] fill_par, st_par, rd_calc;

  l1pg_lpar #(.LB(LB)) u_fill_par (.data(fill_data), .flip(fill_flip), .par(fill_par));
  l1pg_lpar #(.LB(LB)) u_st_par   (.data(st_data),   .flip(st_flip),   .par(st_par));
  l1pg_lpar #(.LB(LB)) u_rd_par   (.data(data_mem[rd_line]), .flip(1'b0), .par(rd_calc));

  // Array storage: no reset; a store byte takes priority over a fill byte.
  always_ff @(posedge clk) begin
    for (int l = 0; l < LINES; l++) begin
      for (int b = 0; b < LB; b++) begin
        if (st_be[b] && st_line == AW'(l)) begin
          data_mem[l][b*8 +: 8] <= st_data[b*8 +: 8];
          par_mem[l][b]         <= st_par[b];
        end else if (fill_en && fill_line == AW'(l)) begin
          data_mem[l][b*8 +: 8] <= fill_data[b*8 +: 8];
          par_mem[l][b]         <= fill_par[b];
        end
      end
    end
  end

  assign rd_data = data_mem[rd_line];
  assign rd_bad  = rd_calc ^ par_mem[rd_line];

  function automatic logic line_clean(input logic [LW-1:0] d, input logic [LB-1:0] p);
    logic ok;
    ok = 1'b1;
    for (int b = 0; b < LB; b++) if ((^d[b*8 +: 8]) != p[b]) ok = 1'b0;
    return ok;
  endfunction

  assert_clean_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !fill_flip && !(|st_be)) |=>
      line_clean(data_mem[$past(fill_line)], par_mem[$past(fill_line)]));
endmodule

// File: rtl/l1_parity_guard.sv
module l1_parity_guard
  import l1pg_pkg::*;
#(
  parameter int LINES      = 8,
  parameter int LINE_BYTES = 4,
  localparam int AW = $clog2(LINES),
  localparam int BW = $clog2(LINE_BYTES),
  localparam int LW = LINE_BYTES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [1:0]    cfg_wdata,
  output logic [1:0]    icfg,
  output logic [1:0]    dcfg,
  input  logic          fill_en,
  input  logic          fill_side,
  input  logic [AW-1:0] fill_line,
  input  logic [LW-1:0] fill_data,
  input  logic          st_en,
  input  logic [1:0]    st_kind,
  input  logic [AW-1:0] st_line,
  input  logic [BW-1:0] st_byte,
  input  logic [7:0]    st_data,
  input  logic          rd_en,
  input  logic          rd_side,
  input  logic [AW-1:0] rd_line,
  output logic [LW-1:0] rd_data,
  output logic          rd_perr
);
  logic [1:0] rst_sync;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  side_ctl_t ictl, dctl;

  l1pg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_int), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ictl(ictl), .dctl(dctl)
  );

  assign icfg = ictl;
  assign dcfg = dctl;

  // Store decode: byte enables and line-wide write data.
  logic [LINE_BYTES-1:0] st_be;
  logic [LW-1:0]         st_line_data;

  always_comb begin
    st_be        = '0;
    st_line_data = '0;
    if (st_en) begin
      case (st_kind_e'(st_kind))
        STK_BYTE: begin
          st_be[st_byte] = 1'b1;
          st_line_data   = {LINE_BYTES{st_data}};
        end
        STK_ZERO, STK_ALLOC: st_be = '1;
        default: st_be = '0;
      endcase
    end
  end

  logic [LW-1:0]         bank_rd  [2];
  logic [LINE_BYTES-1:0] bank_bad [2];
  logic                  side_chk [2];

  assign side_chk[0] = ictl.check;
  assign side_chk[1] = dctl.check;

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic                  flip;
    logic [LINE_BYTES-1:0] be;
    assign flip = (s == 1) ? dctl.inject : ictl.inject;
    assign be   = (s == 1) ? st_be : '0;

    l1pg_bank #(.LINES(LINES), .LB(LINE_BYTES)) u_bank (
      .clk(clk), .rst_n(rst_n_int),
      .fill_en(fill_en && fill_side == 1'(s)), .fill_line(fill_line),
      .fill_data(fill_data), .fill_flip(flip),
      .st_be(be), .st_line(st_line), .st_data(st_line_data), .st_flip(flip),
      .rd_line(rd_line), .rd_data(bank_rd[s]), .rd_bad(bank_bad[s])
    );
  end

  logic [LW-1:0] rd_data_q, rd_data_d;
  logic          rd_perr_q, rd_perr_d;

  always_comb begin
    rd_data_d = rd_data_q;
    if (rd_en) rd_data_d = bank_rd[rd_side];
    rd_perr_d = rd_en && side_chk[rd_side] && (|bank_bad[rd_side]);
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rd_data_q <= '0;
      rd_perr_q <= 1'b0;
    end else begin
      rd_data_q <= rd_data_d;
      rd_perr_q <= rd_perr_d;
    end
  end

  assign rd_data = rd_data_q;
  assign rd_perr = rd_perr_q;

  assert_perr_follows_read_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    rd_perr |-> $past(rd_en));

  assert_perr_needs_check_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
    rd_perr |-> $past(rd_side ? dctl.check : ictl.check));
endmodule

// File: tb/l1_parity_guard_test.sv
module l1_parity_guard_test;
  localparam int AW = 3;
  localparam int BW = 2;
  localparam int LW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [1:0] cfg_wdata = 0;
  logic [1:0] icfg, dcfg;
  logic fill_en = 0, fill_side = 0;
  logic [AW-1:0] fill_line = 0;
  logic [LW-1:0] fill_data = 0;
  logic st_en = 0;
  logic [1:0] st_kind = 0;
  logic [AW-1:0] st_line = 0;
  logic [BW-1:0] st_byte = 0;
  logic [7:0] st_data = 0;
  logic rd_en = 0, rd_side = 0;
  logic [AW-1:0] rd_line = 0;
  logic [LW-1:0] rd_data;
  logic rd_perr;

  int nvec = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  l1_parity_guard uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .icfg(icfg), .dcfg(dcfg), .fill_en(fill_en), .fill_side(fill_side),
    .fill_line(fill_line), .fill_data(fill_data), .st_en(st_en), .st_kind(st_kind),
    .st_line(st_line), .st_byte(st_byte), .st_data(st_data), .rd_en(rd_en),
    .rd_side(rd_side), .rd_line(rd_line), .rd_data(rd_data), .rd_perr(rd_perr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [1:0] wd);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = wd;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic fill(input logic side, input logic [AW-1:0] line, input logic [LW-1:0] d);
    @(negedge clk);
    fill_en = 1; fill_side = side; fill_line = line; fill_data = d;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic store(input logic [1:0] kind, input logic [AW-1:0] line,
                       input logic [BW-1:0] b, input logic [7:0] d);
    @(negedge clk);
    st_en = 1; st_kind = kind; st_line = line; st_byte = b; st_data = d;
    @(negedge clk);
    st_en = 0;
  endtask

  task automatic read_chk(input string req, input logic side, input logic [AW-1:0] line,
                          input logic [LW-1:0] exp_d, input logic exp_p);
    @(negedge clk);
    rd_en = 1; rd_side = side; rd_line = line;
    @(negedge clk);
    rd_en = 0;
    check(req, rd_data, exp_d);
    check(req, {31'd0, rd_perr}, {31'd0, exp_p});
  endtask

  task automatic t_reset();
    check("R1 icfg", {30'd0, icfg}, 32'd0);
    check("R1 dcfg", {30'd0, dcfg}, 32'd0);
    check("R1 rd_perr", {31'd0, rd_perr}, 32'd0);
  endtask

  task automatic t_cfg_rules();
    cfg_write(1, 2'b10); check("R2 data inject w/o check", {30'd0, dcfg}, 32'd0);
    cfg_write(0, 2'b10); check("R2 instr inject w/o check", {30'd0, icfg}, 32'd0);
    cfg_write(1, 2'b11); check("R2 data set both", {30'd0, dcfg}, 32'd3);
    cfg_write(1, 2'b10); check("R2 data clear check clears inject", {30'd0, dcfg}, 32'd0);
    cfg_write(0, 2'b11); check("R2 instr set both", {30'd0, icfg}, 32'd3);
    cfg_write(0, 2'b01); check("R2 instr check only", {30'd0, icfg}, 32'd1);
  endtask

  task automatic t_instr_inject();
    fill(0, 3'd1, 32'h1122_3344);
    read_chk("R3 clean instr read", 0, 3'd1, 32'h1122_3344, 0);
    cfg_write(0, 2'b11);
    fill(0, 3'd1, 32'hA5A5_0F0F);
    read_chk("R4 instr injected fill", 0, 3'd1, 32'hA5A5_0F0F, 1);
    cfg_write(1, 2'b01);
    fill(1, 3'd1, 32'hDEAD_BEEF);
    read_chk("R10 data side unaffected", 1, 3'd1, 32'hDEAD_BEEF, 0);
    cfg_write(0, 2'b01);
    fill(0, 3'd1, 32'h0102_0304);
    read_chk("R8 instr rewrite clean", 0, 3'd1, 32'h0102_0304, 0);
  endtask

  task automatic t_data_inject();
    cfg_write(1, 2'b11);
    fill(1, 3'd3, 32'hCAFE_F00D);
    read_chk("R5 data injected fill", 1, 3'd3, 32'hCAFE_F00D, 1);
    cfg_write(1, 2'b01);
    fill(1, 3'd3, 32'h7777_0000);
    read_chk("R8 data rewrite clean", 1, 3'd3, 32'h7777_0000, 0);
  endtask

  task automatic t_stores();
    cfg_write(1, 2'b01);
    fill(1, 3'd4, 32'h4444_4444);
    store(2'd0, 3'd4, 2'd2, 8'h5A);
    read_chk("R6 clean byte store", 1, 3'd4, 32'h445A_4444, 0);
    fill(1, 3'd5, 32'hFFFF_FFFF);
    fill(1, 3'd6, 32'h1234_5678);
    cfg_write(1, 2'b11);
    store(2'd0, 3'd4, 2'd0, 8'h81);
    read_chk("R6 injected byte store", 1, 3'd4, 32'h445A_4481, 1);
    store(2'd1, 3'd5, 2'd0, 8'h00);
    read_chk("R6 injected zero-line", 1, 3'd5, 32'h0, 1);
    store(2'd2, 3'd6, 2'd1, 8'hEE);
    read_chk("R6 injected allocate", 1, 3'd6, 32'h0, 1);
    store(2'd3, 3'd6, 2'd1, 8'hEE);
    read_chk("R6 kind 3 writes nothing", 1, 3'd6, 32'h0, 1);
  endtask

  task automatic t_check_gate();
    cfg_write(1, 2'b00);
    read_chk("R7 corrupted line, check off", 1, 3'd5, 32'h0, 0);
    cfg_write(1, 2'b01);
    read_chk("R7 corrupted line, check on", 1, 3'd5, 32'h0, 1);
  endtask

  task automatic t_same_cycle();
    cfg_write(1, 2'b01);
    fill(1, 3'd2, 32'h1010_2020);
    @(negedge clk);
    fill_en = 1; fill_side = 1; fill_line = 3'd2; fill_data = 32'h9988_7766;
    st_en = 1; st_kind = 2'd0; st_line = 3'd2; st_byte = 2'd2; st_data = 8'hA5;
    rd_en = 1; rd_side = 1; rd_line = 3'd2;
    @(negedge clk);
    fill_en = 0; st_en = 0; rd_en = 0;
    check("R9 read sees old line", rd_data, 32'h1010_2020);
    check("R9 old line clean", {31'd0, rd_perr}, 32'd0);
    read_chk("R9 store over fill", 1, 3'd2, 32'h99A5_7766, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_cfg_rules();
    t_instr_inject();
    t_data_inject();
    t_stores();
    t_check_gate();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nvec++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule